// File: doc/BRIEF.md
# Selectable Event Counter Bank

This block is a bank of sixteen event counters. Software reaches it through a small register port. For each counter, software sets three things: an enable bit, a selection word and a 48-bit accumulator. The selection word holds a metric code and a hart index. While a counter is enabled, its accumulator adds the per-cycle increment of the chosen source on every clock edge. An increment can be larger than one, such as a count of simultaneous accesses or a byte count.

There are three kinds of source. Cluster-wide sources report the number of memory accesses and congested accesses in each cycle. Per-hart sources are single-bit issue, retire and instruction-cache events, one set for each hart. DMA-local sources supply an increment value for each DMA metric, and for the bandwidth metrics that value is a byte count. If the hart index is larger than the number of harts, it wraps modulo the hart count. Each counter makes its own selection, so two counters can watch the same event on different harts.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every enable bit is 1, every selection word is 0 and every accumulator is 0. All counters therefore start counting cycles at once.
- R2: Bits addr[8:7] of the byte address select the register group: 0 is enable, 1 is selection, 2 is accumulator and 3 is unmapped. addr[6:3] gives the counter number, so registers sit 8 bytes apart. An unmapped read returns 0, and an unmapped write changes nothing.
- R3: Unimplemented bits read as zero: enable bits 63:1, selection bits 63:32 and accumulator bits 63:48.
- R4: A counter whose enable bit is 0 holds its value.
- R5: Metric code 0 adds 1 on every edge.
- R6: Metric code 1 adds the access-count input, and metric code 2 adds the congestion-count input.
- R7: Metric codes 3 to 9 and 0x1A to 0x1E take a per-hart event from hart (index mod hart count). The event bit for a code is hart_evt_i[h*12 + (code[3:0]-3)].
- R8: Metric codes 0x0A to 0x19 add the DMA increment at slot ((code[3:0]-0xA) mod 16), found at dma_inc_i[slot*INC_W +: INC_W]. A byte-count slot adds its full value.
- R9: Any metric code above 0x1E adds nothing.
- R10: If software writes an accumulator on the same edge that an increment would occur, the written value is kept.
- R11: An accumulator wraps from 2^48-1 to 0 and sets no flag.
- R12: Read data appears on rdata_o after the edge that samples the read. It stays unchanged until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 means write, 0 means read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| glb_acc_i | input | INC_W | Memory accesses in this cycle |
| glb_cong_i | input | INC_W | Accesses refused in this cycle |
| hart_evt_i | input | NUM_HARTS*12 | Per-hart single-bit events |
| dma_inc_i | input | 16*INC_W | DMA increment values, one per DMA metric |

## Verification
A register write takes effect on the edge that samples it, and read data appears after the edge that samples the read. The bench therefore drives and samples on falling edges, with each access taking exactly one rising edge. An accumulator changes on every edge at which its enable bit is 1. Suppose the enable is set on edge A, there are M idle edges, and the enable is cleared on the next edge. The accumulator then gains exactly (M+1) increments, and every expected total is derived from that count. For read latency, the bench checks rdata_o just before the sampling edge and again after it. It also confirms that idle cycles and writes leave rdata_o unchanged.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int DATA_W     = 64;
  localparam int HART_EVT_N = 12;
  localparam int DMA_EVT_N  = 16;

  localparam logic [15:0] M_CYCLE     = 16'h0000;
  localparam logic [15:0] M_GLB_ACC   = 16'h0001;
  localparam logic [15:0] M_GLB_CONG  = 16'h0002;
  localparam logic [15:0] M_HLO_FIRST = 16'h0003;
  localparam logic [15:0] M_HLO_LAST  = 16'h0009;
  localparam logic [15:0] M_DMA_FIRST = 16'h000a;
  localparam logic [15:0] M_DMA_LAST  = 16'h0019;
  localparam logic [15:0] M_HHI_FIRST = 16'h001a;
  localparam logic [15:0] M_HHI_LAST  = 16'h001e;

  typedef enum logic [1:0] {
    RGN_EN   = 2'd0,
    RGN_SEL  = 2'd1,
    RGN_CNT  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef struct packed {
    logic [15:0] metric;
    logic [15:0] hart;
  } sel_t;
endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_bank_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 9
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output region_e            region_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               rd_o,
  output logic [NUM_CTR-1:0] en_we_o,
  output logic [NUM_CTR-1:0] sel_we_o,
  output logic [NUM_CTR-1:0] cnt_we_o
);
  logic wr;
  logic unused_lsb;

  assign region_o   = region_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx_o      = addr_i[3 +: IDX_W];
  assign rd_o       = req_i & ~we_i;
  assign wr         = req_i & we_i;
  assign unused_lsb = ^addr_i[2:0];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_strobe
    logic hit;
    assign hit         = wr && (idx_o == IDX_W'(i));
    assign en_we_o[i]  = hit && (region_o == RGN_EN);
    assign sel_we_o[i] = hit && (region_o == RGN_SEL);
    assign cnt_we_o[i] = hit && (region_o == RGN_CNT);
  end
endmodule

// File: rtl/evt_source_mux.sv
module evt_source_mux
  import evt_bank_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int INC_W     = 8,
  localparam int HART_IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  sel_t                              sel_i,
  input  logic [INC_W-1:0]                  glb_acc_i,
  input  logic [INC_W-1:0]                  glb_cong_i,
  input  logic [NUM_HARTS*HART_EVT_N-1:0]   hart_evt_i,
  input  logic [DMA_EVT_N*INC_W-1:0]        dma_inc_i,
  output logic [INC_W-1:0]                  inc_o
);
  logic [HART_IDX_W-1:0] hart_idx;
  logic [HART_EVT_N-1:0] hsel_evt;
  logic [3:0]            hslot;
  logic [3:0]            dslot;
  logic [15:0]           m;

  // Power-of-two hart counts wrap by truncation; others need a real modulo.
  if (NUM_HARTS > 1 && (NUM_HARTS & (NUM_HARTS - 1)) == 0) begin : g_wrap_mask
    logic unused_hart_hi;
    assign unused_hart_hi = ^sel_i.hart;
    assign hart_idx = sel_i.hart[HART_IDX_W-1:0];
  end else begin : g_wrap_mod
    assign hart_idx = HART_IDX_W'(sel_i.hart % 16'(NUM_HARTS));
  end

  assign m        = sel_i.metric;
  assign hsel_evt = hart_evt_i[int'(hart_idx)*HART_EVT_N +: HART_EVT_N];
  // both hart ranges map onto slots 0..6 and 7..11 by the same subtraction
  assign hslot    = m[3:0] - 4'd3;
  assign dslot    = m[3:0] - 4'ha;

  always_comb begin
    inc_o = '0;
    if (m == M_CYCLE) begin
      inc_o = INC_W'(1);
    end else if (m == M_GLB_ACC) begin
      inc_o = glb_acc_i;
    end else if (m == M_GLB_CONG) begin
      inc_o = glb_cong_i;
    end else if ((m >= M_HLO_FIRST && m <= M_HLO_LAST) ||
                 (m >= M_HHI_FIRST && m <= M_HHI_LAST)) begin
      inc_o = INC_W'(hsel_evt[hslot]);
    end else if (m >= M_DMA_FIRST && m <= M_DMA_LAST) begin
      inc_o = dma_inc_i[int'(dslot)*INC_W +: INC_W];
    end
  end
endmodule

// File: rtl/evt_counter_slice.sv
module evt_counter_slice
  import evt_bank_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int INC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              sel_we_i,
  input  logic              cnt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic              en_o,
  output sel_t              sel_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b1;
      sel_o <= '0;
    end else begin
      if (en_we_i)  en_o  <= wdata_i[0];
      if (sel_we_i) sel_o <= sel_t'(wdata_i[$bits(sel_t)-1:0]);
    end
  end

  // software write has priority over the event increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (cnt_we_i) cnt_o <= wdata_i[CNT_W-1:0];
    else if (en_o)     cnt_o <= cnt_o + CNT_W'(inc_i);
  end
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evt_bank_pkg::*;
#(
  parameter int NUM_CTR   = 16,
  parameter int NUM_HARTS = 4,
  parameter int CNT_W     = 48,
  parameter int INC_W     = 8,
  localparam int IDX_W    = $clog2(NUM_CTR),
  localparam int ADDR_W   = IDX_W + 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic [INC_W-1:0]                 glb_acc_i,
  input  logic [INC_W-1:0]                 glb_cong_i,
  input  logic [NUM_HARTS*HART_EVT_N-1:0]  hart_evt_i,
  input  logic [DMA_EVT_N*INC_W-1:0]       dma_inc_i
);
  region_e            region;
  logic [IDX_W-1:0]   idx;
  logic               rd;
  logic [NUM_CTR-1:0] en_we, sel_we, cnt_we;
  logic [NUM_CTR-1:0] en_vec;
  sel_t               sel_arr [NUM_CTR];
  logic [CNT_W-1:0]   cnt_arr [NUM_CTR];
  logic [DATA_W-1:0]  rd_val;

  evt_reg_decode #(
    .NUM_CTR (NUM_CTR),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
  ) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .region_o (region),
    .idx_o    (idx),
    .rd_o     (rd),
    .en_we_o  (en_we),
    .sel_we_o (sel_we),
    .cnt_we_o (cnt_we)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [INC_W-1:0] inc;

    evt_source_mux #(
      .NUM_HARTS (NUM_HARTS),
      .INC_W     (INC_W)
    ) u_mux (
      .sel_i      (sel_arr[i]),
      .glb_acc_i  (glb_acc_i),
      .glb_cong_i (glb_cong_i),
      .hart_evt_i (hart_evt_i),
      .dma_inc_i  (dma_inc_i),
      .inc_o      (inc)
    );

    evt_counter_slice #(
      .CNT_W (CNT_W),
      .INC_W (INC_W)
    ) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_we_i  (en_we[i]),
      .sel_we_i (sel_we[i]),
      .cnt_we_i (cnt_we[i]),
      .wdata_i  (wdata_i),
      .inc_i    (inc),
      .en_o     (en_vec[i]),
      .sel_o    (sel_arr[i]),
      .cnt_o    (cnt_arr[i])
    );
  end

  always_comb begin
    unique case (region)
      RGN_EN:  rd_val = DATA_W'(en_vec[idx]);
      RGN_SEL: rd_val = DATA_W'(sel_arr[idx]);
      RGN_CNT: rd_val = DATA_W'(cnt_arr[idx]);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/evt_counter_bank_chk.sv
module evt_counter_bank_chk #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [63:0]       wdata_i,
  input logic [63:0]       rdata_o,
  input logic              en0_i,
  input logic [CNT_W-1:0]  cnt0_i
);
  localparam logic [ADDR_W-1:0] CNT0_ADDR = {2'b10, {(ADDR_W-2){1'b0}}};

  logic rd, cnt0_wr;
  assign rd      = req_i && !we_i;
  assign cnt0_wr = req_i && we_i && (addr_i == CNT0_ADDR);

  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  p_unmapped_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i[ADDR_W-1 -: 2] == 2'b11 |=> rdata_o == 64'd0);

  p_en_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i[ADDR_W-1 -: 2] == 2'b00 |=> rdata_o[63:1] == '0);

  p_sel_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i[ADDR_W-1 -: 2] == 2'b01 |=> rdata_o[63:32] == '0);

  p_cnt_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[63:CNT_W] == '0);

  p_disabled_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en0_i && !cnt0_wr |=> $stable(cnt0_i));

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt0_wr |=> cnt0_i == $past(wdata_i[CNT_W-1:0]));
endmodule

bind evt_counter_bank evt_counter_bank_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .en0_i   (en_vec[0]),
  .cnt0_i  (cnt_arr[0])
);

// File: tb/evt_counter_bank_test.sv
module evt_counter_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NH    = 3;
  localparam int INC_W = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [8:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [INC_W-1:0]    glb_acc = '0, glb_cong = '0;
  logic [NH*12-1:0]    hart_evt = '0;
  logic [16*INC_W-1:0] dma_inc = '0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_counter_bank #(.NUM_HARTS(NH), .INC_W(INC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .glb_acc_i(glb_acc),
    .glb_cong_i(glb_cong), .hart_evt_i(hart_evt), .dma_inc_i(dma_inc)
  );

  function automatic logic [8:0] a_en(int i);  return 9'(i*8);         endfunction
  function automatic logic [8:0] a_sel(int i); return 9'(9'h080 + i*8); endfunction
  function automatic logic [8:0] a_cnt(int i); return 9'(9'h100 + i*8); endfunction
  function automatic logic [63:0] selw(logic [15:0] m, logic [15:0] h);
    return {32'd0, m, h};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // each access uses exactly one rising edge; starts and ends at a falling edge
  task automatic wr(logic [8:0] a, logic [63:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [63:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // enabled for exactly m+1 edges
  task automatic run_window(int idx, logic [15:0] m, logic [15:0] h, int n,
                            output logic [63:0] v);
    wr(a_en(idx), 64'd0);
    wr(a_cnt(idx), 64'd0);
    wr(a_sel(idx), selw(m, h));
    wr(a_en(idx), 64'd1);
    idle(n);
    wr(a_en(idx), 64'd0);
    rd(a_cnt(idx), v);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(a_en(3), v);   check("R1 enable reset", v, 64'd1);
    rd(a_sel(3), v);  check("R1 select reset", v, 64'd0);
    rd(a_en(15), v);  check("R1 enable reset last", v, 64'd1);
  endtask

  task automatic t_cycle();
    logic [63:0] v1, v2;
    rd(a_cnt(5), v1);
    rd(a_cnt(5), v2);
    check("R1 count from zero", 64'(v1 < 64'd16), 64'd1);
    check("R5 cycle step", v2, v1 + 64'd1);
  endtask

  task automatic t_reserved_bits();
    logic [63:0] v;
    wr(a_en(2), '1);   rd(a_en(2), v);  check("R3 enable bits", v, 64'd1);
    wr(a_sel(2), '1);  rd(a_sel(2), v); check("R3 select bits", v, 64'h0000_0000_ffff_ffff);
    wr(a_en(2), 64'hffff_ffff_ffff_fffe);
    rd(a_en(2), v);    check("R3 enable only bit0", v, 64'd0);
    wr(a_cnt(2), '1);  rd(a_cnt(2), v); check("R3 counter bits", v, 64'h0000_ffff_ffff_ffff);
  endtask

  task automatic t_hold();
    logic [63:0] v;
    wr(a_sel(2), selw(16'h0000, 16'h0));
    idle(5);
    rd(a_cnt(2), v);   check("R4 disabled holds", v, 64'h0000_ffff_ffff_ffff);
  endtask

  task automatic t_address_map();
    logic [63:0] v;
    wr(a_sel(7), selw(16'h0005, 16'h0002));
    rd(a_sel(7), v);   check("R2 select stride", v, 64'h0005_0002);
    rd(a_sel(6), v);   check("R2 neighbour below", v, 64'd0);
    rd(a_sel(8), v);   check("R2 neighbour above", v, 64'd0);
    wr(9'h180, '1);
    rd(9'h180, v);     check("R2 unmapped read", v, 64'd0);
    rd(a_en(0), v);    check("R2 unmapped write no effect", v, 64'd1);
    rd(a_sel(0), v);   check("R2 unmapped write sel0", v, 64'd0);
    wr(a_sel(7), 64'd0);
  endtask

  task automatic t_global();
    logic [63:0] v;
    glb_acc = 8'd3; glb_cong = 8'd1;
    run_window(1, 16'h0001, 16'h0, 9, v); check("R6 access count", v, 64'd30);
    run_window(1, 16'h0002, 16'h0, 9, v); check("R6 congestion count", v, 64'd10);
    glb_acc = '0; glb_cong = '0;
  endtask

  task automatic t_hart();
    logic [63:0] v;
    hart_evt = '0;
    hart_evt[1*12 + 3] = 1'b1;  // hart 1, code 6
    hart_evt[0*12 + 8] = 1'b1;  // hart 0, code 0x1B
    run_window(3, 16'h0006, 16'd7, 4, v);      check("R7 hart 7 wraps to 1", v, 64'd5);
    run_window(3, 16'h0006, 16'd2, 4, v);      check("R7 other hart silent", v, 64'd0);
    run_window(3, 16'h001b, 16'hffff, 4, v);   check("R7 hart ffff wraps to 0", v, 64'd5);
    run_window(3, 16'h001b, 16'd1, 4, v);      check("R7 upper code hart 1", v, 64'd0);
    hart_evt = '0;
  endtask

  task automatic t_dma();
    logic [63:0] v;
    dma_inc = '0;
    dma_inc[9*INC_W +: INC_W] = 8'd16;  // code 0x13
    dma_inc[0*INC_W +: INC_W] = 8'd1;   // code 0x0A
    run_window(4, 16'h0013, 16'd0, 3, v); check("R8 byte count", v, 64'd64);
    run_window(4, 16'h000a, 16'd0, 3, v); check("R8 stall count", v, 64'd4);
    dma_inc = '0;
  endtask

  task automatic t_reserved_code();
    logic [63:0] v;
    glb_acc = 8'd5; glb_cong = 8'd5; hart_evt = '1; dma_inc = '1;
    run_window(6, 16'h001f, 16'd0, 6, v); check("R9 code 0x1f", v, 64'd0);
    run_window(6, 16'h0100, 16'd0, 6, v); check("R9 code 0x100", v, 64'd0);
    glb_acc = '0; glb_cong = '0; hart_evt = '0; dma_inc = '0;
  endtask

  task automatic t_write_wins();
    logic [63:0] v;
    wr(a_sel(8), 64'd0);
    wr(a_en(8), 64'd1);
    wr(a_cnt(8), 64'd1000);
    rd(a_cnt(8), v);   check("R10 write beats increment", v, 64'd1000);
    rd(a_cnt(8), v);   check("R10 counting resumes", v, 64'd1001);
  endtask

  task automatic t_wrap();
    logic [63:0] v;
    wr(a_cnt(8), 64'h0000_ffff_ffff_ffff);
    rd(a_cnt(8), v);   check("R11 at max", v, 64'h0000_ffff_ffff_ffff);
    rd(a_cnt(8), v);   check("R11 wraps to zero", v, 64'd0);
  endtask

  task automatic t_read_latency();
    logic [63:0] v;
    rd(a_en(0), v);    check("R12 read enable", v, 64'd1);
    wr(a_sel(9), selw(16'h0003, 16'h0001));
    check("R12 held across write", rdata, 64'd1);
    req = 1'b1; we = 1'b0; addr = a_sel(9);
    #1; check("R12 not before edge", rdata, 64'd1);
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    check("R12 after edge", rdata, 64'h0003_0001);
    idle(3);
    check("R12 held while idle", rdata, 64'h0003_0001);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_cycle();
    t_reserved_bits();
    t_hold();
    t_address_map();
    t_global();
    t_hart();
    t_dma();
    t_reserved_code();
    t_write_wins();
    t_wrap();
    t_read_latency();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end
endmodule